// File: doc/BRIEF.md
# Dataflow Token Router

This block sits at the entry of a small dataflow core. Tokens reach it from two sources. One is an external port that loads new operands from outside the processor. The other is an internal port that carries results fed back from the execution unit. Each source is held in its own small FIFO. Every cycle the router picks at most one head token and steers it by its destination. Tokens addressed to ordinary graph nodes go to the matcher's input buffer. Tokens carrying the reserved output address leave the processor on a separate result port.

Every link uses a valid strobe plus a full flag from the receiver. A head token is removed from its FIFO only in the cycle its chosen target takes it. Results already circulating inside the core always go ahead of fresh external tokens, so a graph in flight is never held up by new work.

Top module: `df_token_router`

## Requirements
- R1: A token is 24 bits. The signed 16-bit data value is in bits 23:8, the 7-bit node address in bits 7:1, and the side select in bit 0 (0 = left operand, 1 = right operand). A token leaves the block bit for bit as it entered.
- R2: A token whose node address is 127 (all ones) is sent only on the result port (`res_valid`/`res_token`) and never toward the matcher.
- R3: A token whose node address is 0 to 126 is sent only toward the matcher (`mt_valid`/`mt_token`) and never on the result port.
- R4: When both input FIFOs hold a token, the internal head is the only candidate that cycle. This holds even when its target is full.
- R5: When the internal FIFO is empty, the external head token is forwarded in that cycle, provided its target is not full.
- R6: No valid is raised on a link while that link's full input is high. The blocked token stays at its FIFO head and leaves in the first cycle the target is free.
- R7: Tokens from one input leave in the order they were written.
- R8: An input's full flag is high exactly while its FIFO holds FIFO_DEPTH tokens (default 4). A write offered while the flag is high is dropped.
- R9: After reset both FIFOs are empty, both full flags are low, and neither output valid is raised.
- R10: A token written at a clock edge into an empty FIFO, with no other token queued ahead of it and its target free, appears on its output after that same edge.
- R11: At most one token leaves the block per cycle. `mt_valid` and `res_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_valid | input | 1 | External token offered |
| ext_token | input | 24 | External token |
| ext_full | output | 1 | External FIFO full |
| fb_valid | input | 1 | Feedback token offered |
| fb_token | input | 24 | Feedback token |
| fb_full | output | 1 | Feedback FIFO full |
| mt_valid | output | 1 | Token sent toward matcher |
| mt_token | output | 24 | Token toward matcher |
| mt_full | input | 1 | Matcher buffer full |
| res_valid | output | 1 | Result token leaving processor |
| res_token | output | 24 | Result token |
| res_full | input | 1 | Result receiver full |

## Verification
A write is registered at the edge where it is offered. From that edge on it is visible at the FIFO head, so its output is due after that one edge, and the full flags change after the same edge. Output valids respond within the cycle to `mt_full` and `res_full`. The bench drives all inputs just after the falling edge and waits one time step before comparing. It then lets the rising edge commit, and moves its queue model at that same edge, so every expected value refers to the same cycle as the outputs it is compared with.

// File: rtl/df_router_pkg.sv
package df_router_pkg;

    localparam int VALUE_W = 16;
    localparam int NODE_W  = 7;
    localparam int TOKEN_W = VALUE_W + NODE_W + 1;

    // node address reserved for tokens that leave the processor
    localparam logic [NODE_W-1:0] RESULT_NODE = {NODE_W{1'b1}};

    typedef struct packed {
        logic signed [VALUE_W-1:0] value;
        logic [NODE_W-1:0]         node;
        logic                      side;   // 0 left, 1 right
    } token_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_FB   = 2'd1,
        SRC_EXT  = 2'd2
    } src_e;

endpackage

// File: rtl/df_token_fifo.sv
module df_token_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [WIDTH-1:0] wr_data,
    output logic             full,
    output logic             head_valid,
    output logic [WIDTH-1:0] head_data,
    input  logic             rd_pop
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [PTR_W-1:0]            rd;
        logic [PTR_W-1:0]            wr;
        logic [CNT_W-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic push, pop;

    assign full       = (st_q.cnt == CAP);
    assign head_valid = (st_q.cnt != '0);
    assign head_data  = st_q.mem[st_q.rd];

    always_comb begin
        st_d = st_q;
        push = wr_valid && !full;
        pop  = rd_pop && head_valid;
        if (push) begin
            st_d.mem[st_q.wr] = wr_data;
            st_d.wr = (st_q.wr == LAST) ? '0 : st_q.wr + 1'b1;
        end
        if (pop) begin
            st_d.rd = (st_q.rd == LAST) ? '0 : st_q.rd + 1'b1;
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/df_route_arbiter.sv
module df_route_arbiter
    import df_router_pkg::*;
(
    input  logic   fb_head_valid,
    input  token_t fb_head,
    input  logic   ext_head_valid,
    input  token_t ext_head,
    input  logic   mt_full,
    input  logic   res_full,
    output logic   mt_valid,
    output token_t mt_token,
    output logic   res_valid,
    output token_t res_token,
    output logic   fb_pop,
    output logic   ext_pop
);
    src_e   sel;
    token_t cand;
    logic   to_result;
    logic   accepted;

    always_comb begin
        // feedback results go first whenever present
        if (fb_head_valid)       sel = SRC_FB;
        else if (ext_head_valid) sel = SRC_EXT;
        else                     sel = SRC_NONE;

        cand      = (sel == SRC_FB) ? fb_head : ext_head;
        to_result = (cand.node == RESULT_NODE);

        mt_valid  = (sel != SRC_NONE) && !to_result && !mt_full;
        res_valid = (sel != SRC_NONE) &&  to_result && !res_full;
        mt_token  = cand;
        res_token = cand;
        accepted  = mt_valid || res_valid;

        fb_pop  = accepted && (sel == SRC_FB);
        ext_pop = accepted && (sel == SRC_EXT);
    end

endmodule

// File: rtl/df_token_router.sv
module df_token_router
    import df_router_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_valid,
    input  logic [TOKEN_W-1:0] ext_token,
    output logic               ext_full,
    input  logic               fb_valid,
    input  logic [TOKEN_W-1:0] fb_token,
    output logic               fb_full,
    output logic               mt_valid,
    output logic [TOKEN_W-1:0] mt_token,
    input  logic               mt_full,
    output logic               res_valid,
    output logic [TOKEN_W-1:0] res_token,
    input  logic               res_full
);
    localparam int N_IN = 2;   // 0 feedback, 1 external

    logic [N_IN-1:0]              in_valid, in_full, head_valid, pop;
    logic [N_IN-1:0][TOKEN_W-1:0] in_data, head_data;
    token_t mt_tok, res_tok;

    assign in_valid = {ext_valid, fb_valid};
    assign in_data  = {ext_token, fb_token};
    assign fb_full  = in_full[0];
    assign ext_full = in_full[1];

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        df_token_fifo #(
            .DEPTH (FIFO_DEPTH),
            .WIDTH (TOKEN_W)
        ) u_fifo (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_valid   (in_valid[i]),
            .wr_data    (in_data[i]),
            .full       (in_full[i]),
            .head_valid (head_valid[i]),
            .head_data  (head_data[i]),
            .rd_pop     (pop[i])
        );
    end

    df_route_arbiter u_arb (
        .fb_head_valid  (head_valid[0]),
        .fb_head        (token_t'(head_data[0])),
        .ext_head_valid (head_valid[1]),
        .ext_head       (token_t'(head_data[1])),
        .mt_full        (mt_full),
        .res_full       (res_full),
        .mt_valid       (mt_valid),
        .mt_token       (mt_tok),
        .res_valid      (res_valid),
        .res_token      (res_tok),
        .fb_pop         (pop[0]),
        .ext_pop        (pop[1])
    );

    assign mt_token  = mt_tok;
    assign res_token = res_tok;

endmodule

// File: rtl/df_token_router_chk.sv
module df_token_router_chk
    import df_router_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               ext_valid,
    input logic [TOKEN_W-1:0] ext_token,
    input logic               ext_full,
    input logic               fb_valid,
    input logic [TOKEN_W-1:0] fb_token,
    input logic               fb_full,
    input logic               mt_valid,
    input logic [TOKEN_W-1:0] mt_token,
    input logic               mt_full,
    input logic               res_valid,
    input logic [TOKEN_W-1:0] res_token,
    input logic               res_full
);
    // R2
    result_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_token[NODE_W:1] == RESULT_NODE));

    // R3
    matcher_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mt_valid |-> (mt_token[NODE_W:1] != RESULT_NODE));

    // R6
    mt_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mt_full |-> !mt_valid);

    // R6
    res_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_full |-> !res_valid);

    // R11
    single_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mt_valid && res_valid));

    // R8
    ext_full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_full) |-> $past(ext_valid));

    // R8
    fb_full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fb_full) |-> $past(fb_valid));

endmodule

bind df_token_router df_token_router_chk u_chk (.*);

// File: tb/df_token_router_test.sv
`timescale 1ns/1ps
module df_token_router_test;
    localparam int DEPTH = 4;
    localparam logic [6:0] RNODE = 7'h7F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_valid = 1'b0, fb_valid = 1'b0, mt_full = 1'b0, res_full = 1'b0;
    logic [23:0] ext_token = '0, fb_token = '0;
    logic ext_full, fb_full, mt_valid, res_valid;
    logic [23:0] mt_token, res_token;

    always #10 clk = ~clk;

    df_token_router #(.FIFO_DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .ext_valid(ext_valid), .ext_token(ext_token), .ext_full(ext_full),
        .fb_valid(fb_valid), .fb_token(fb_token), .fb_full(fb_full),
        .mt_valid(mt_valid), .mt_token(mt_token), .mt_full(mt_full),
        .res_valid(res_valid), .res_token(res_token), .res_full(res_full)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;
    string phase = "R9";
    logic [23:0] q_ext[$];
    logic [23:0] q_fb[$];

    function automatic logic [23:0] mk(input int v, input int node, input bit side);
        return {16'(v), 7'(node), side};
    endfunction

    task automatic cmp(input string what, input logic [23:0] act, input logic [23:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%h expected=%h", phase, what, act, exp);
        end
    endtask

    // one cycle: drive, compare against queue model, clock, update model
    task automatic step(input bit ev, input logic [23:0] ed, input bit fv,
                        input logic [23:0] fd, input bit cf, input bit rf);
        logic [23:0] head;
        bit have, from_fb, to_res, exp_mt, exp_res, ext_was_full, fb_was_full;
        ext_valid = ev; ext_token = ed; fb_valid = fv; fb_token = fd;
        mt_full = cf; res_full = rf;
        #1;
        have = (q_fb.size() > 0) || (q_ext.size() > 0);
        from_fb = q_fb.size() > 0;
        head = from_fb ? q_fb[0] : (have ? q_ext[0] : '0);
        to_res = have && (head[7:1] == RNODE);
        exp_mt = have && !to_res && !cf;
        exp_res = have && to_res && !rf;
        ext_was_full = q_ext.size() == DEPTH;
        fb_was_full = q_fb.size() == DEPTH;
        cmp("mt_valid", {23'd0, mt_valid}, {23'd0, exp_mt});
        cmp("res_valid", {23'd0, res_valid}, {23'd0, exp_res});
        if (exp_mt)  cmp("mt_token", mt_token, head);
        if (exp_res) cmp("res_token", res_token, head);
        cmp("ext_full", {23'd0, ext_full}, {23'd0, ext_was_full});
        cmp("fb_full", {23'd0, fb_full}, {23'd0, fb_was_full});
        @(posedge clk);
        if (exp_mt || exp_res) begin
            if (from_fb) void'(q_fb.pop_front());
            else         void'(q_ext.pop_front());
        end
        if (ev && !ext_was_full) q_ext.push_back(ed);
        if (fv && !fb_was_full)  q_fb.push_back(fd);
        @(negedge clk);
    endtask

    task automatic idle(input int n, input bit cf, input bit rf);
        for (int k = 0; k < n; k++) step(0, '0, 0, '0, cf, rf);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        cmp("mt_valid", {23'd0, mt_valid}, 24'd0);
        cmp("res_valid", {23'd0, res_valid}, 24'd0);
        cmp("ext_full", {23'd0, ext_full}, 24'd0);
        cmp("fb_full", {23'd0, fb_full}, 24'd0);
        rst_n = 1'b1;
        idle(2, 0, 0);

        // R1 R3 R10: every ordinary node, both sides, one token per cycle
        phase = "R1 R3 R10 sweep";
        for (int n = 0; n < 127; n++)
            for (int s = 0; s < 2; s++)
                step(1, mk(n * 257 - 16000 + s, n, s[0]), 0, '0, 0, 0);
        idle(2, 0, 0);

        // R2: result-bound tokens from both inputs
        phase = "R2 result steering";
        for (int v = -4; v < 4; v++) begin
            step(1, mk(v * 1000, 127, v[0]), 0, '0, 0, 0);
            step(0, '0, 1, mk(v * 7, 127, ~v[0]), 0, 0);
        end
        idle(3, 0, 0);

        // R4 R5: simultaneous writes, all destination mixes
        phase = "R4 R5 priority";
        for (int a = 0; a < 4; a++) begin
            step(1, mk(100 + a, (a & 1) ? 127 : 5, 0), 1, mk(-100 - a, (a & 2) ? 127 : 9, 1), 0, 0);
            idle(3, 0, 0);
        end
        // R4: feedback head blocked, external must wait
        step(1, mk(11, 3, 0), 1, mk(22, 127, 0), 0, 1);
        idle(3, 0, 1);
        idle(3, 0, 0);

        // R6: back-pressure holds tokens, release later
        phase = "R6 back-pressure";
        step(1, mk(31, 2, 0), 0, '0, 1, 1);
        step(1, mk(32, 127, 1), 0, '0, 1, 1);
        idle(4, 1, 1);
        idle(2, 0, 1);
        idle(3, 0, 0);

        // R7 R8: fill both FIFOs beyond depth, then drain in order
        phase = "R7 R8 fill";
        for (int k = 0; k < DEPTH + 2; k++)
            step(1, mk(500 + k, 10 + k, k[0]), 1, mk(600 + k, 20 + k, k[0]), 1, 1);
        idle(2 * DEPTH + 2, 0, 0);

        // R11: feedback to result, external to matcher in same cycles
        phase = "R11 single issue";
        for (int k = 0; k < 3; k++)
            step(1, mk(700 + k, 40, 0), 1, mk(800 + k, 127, 1), 0, 0);
        idle(8, 0, 0);

        // mixed traffic from an LFSR
        phase = "R4 R6 R7 R11 mixed";
        begin
            logic [15:0] lf = 16'hACE1;
            for (int k = 0; k < 3000; k++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                step(lf[0], mk(int'(lf), lf[3] ? 127 : int'(lf[9:4]), lf[1]),
                     lf[2], mk(-int'(lf), lf[5] ? 127 : int'(lf[12:7]), lf[4]),
                     lf[6] & lf[8], lf[11] & lf[14]);
            end
        end
        idle(12, 0, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog R10 actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule